// File: doc/BRIEF.md
# DDR4 MR6 Initialization Command Sequencer

This block produces the cycle-by-cycle command stream that programs DDR4 mode register 6 on every populated rank behind one memory port. One `start` pulse makes it raise CKE with a wake-up NOP and then hold off for the reset-CKE-exit time. It then walks the rank slots in ascending order, with slot index = rank + 4 × DIMM. For each populated slot it writes the MR6 word built from that slot's VrefDQ training settings and the shared tCCD_L value. A NOP and a tMOD hold-off close each slot.

Registered and load-reduced DIMMs get a second, inverted copy of each MR6 write for the B-side DRAMs. Ranks flagged in the mirror mask get their address and bank bits swapped after any inversion. 3DS stacks have extra chip selects driven low and CKE bit 1 dropped during rank commands.

The controller is a single state machine with these states:
- ST_IDLE: waits for `start`. The transition taken on `start` is named launch.
- ST_WAKE_NOP: issues the wake-up NOP.
- ST_MR6_A: issues the primary MR6 write.
- ST_MR6_B: issues the B-side MR6 write.
- ST_TMOD_NOP: issues the per-rank closing NOP.
- ST_GAP: counts deselect cycles. When the count expires it takes one of three transitions: scan (to the next populated slot), finish (no slot left), or resume (to the stored command state).
- ST_FINISH: raises `done`.

Top module: `mr6_init_seq`

## Requirements
- R1: While and after reset, until the first `start`, the outputs idle: `cmd_cke`=0, `cmd_cs_n` all ones, RAS/CAS/WE high, `cmd_bank`=0, `cmd_addr`=0, `busy`=0, `done`=0.
- R2: The cycle after `start` is sampled in idle is a NOP: CKE all ones, all chip selects high, RAS/CAS/WE high, bank and address zero. It is followed by XPR_IDLE deselect cycles (all chip selects high, RAS/CAS/WE high, address and bank zero, CKE all ones).
- R3: The MR6 word on `cmd_addr` has these fields:
  - bits 5:0 carry the slot's VrefDQ value;
  - bit 6 carries the range (0 = range 1, 1 = range 2);
  - bit 7 carries the training enable;
  - bits 12:10 carry tCCD_L minus 4, so 4,5,6,7,8 clocks give 0,1,2,3,4;
  - bits 9:8, 13, 14 and 15 are zero.
- R4: An MR6 command drives RAS, CAS and WE low, with `cmd_bank` = {BG0,BA1,BA0} = 3'b110 before mirroring. Each MR6 command is followed by MRS_IDLE deselect cycles.
- R5: During a rank command only chip select bit (rank + 4 × DIMM) is low. Slots are visited in ascending order. A DIMM whose rank count is 0 contributes no command.
- R6: With `stack_3ds`=1, chip selects 2, 3, 6 and 7 are also low during rank commands, and `cmd_cke`[1] is low in those cycles only.
- R7: With `dimm_regd`=1, the primary MR6 and its gap are followed by a B-side MR6. Its address is the primary word XOR 16'h6BF8 (bits 3–9, 11, 13 and 14, bit 14 carrying A17) with bit 15 (BG1) set, and its bank bits are all inverted.
- R8: After a slot's last MR6 and its gap comes a NOP cycle (RAS/CAS/WE high, that slot's chip selects as in R5/R6, address and bank zero) and then MOD_IDLE deselect cycles.
- R9: When bit (3 − rank) of the DIMM's 4-bit field in `mirror_mask` is set, the address and bank are mirrored after any B-side inversion:
  - A3↔A4, A5↔A6, A7↔A8 and A11↔A13 are swapped;
  - BA0↔BA1 are swapped;
  - BG0 (`cmd_bank`[2]) ↔ BG1 (`cmd_addr`[15]) are swapped;
  - all other bits pass through unchanged.
- R10: `busy` is high from the wake-up NOP through the last deselect cycle. `done` is a one-cycle pulse in the following cycle, and no chip select is low while `busy` is low.
- R11: A `start` pulse while `busy` is high has no effect on the command stream.
- R12: After `done`, the outputs idle at deselect with `cmd_cke` all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse, honoured only in idle |
| ranks_per_dimm | input | DIMMS*3 | Rank count per DIMM (0..4), DIMM 0 in the low field |
| dimm_regd | input | 1 | 1 = registered or load-reduced DIMMs (B-side copy) |
| stack_3ds | input | 1 | 1 = 3DS stacked DRAMs |
| mirror_mask | input | DIMMS*RANKS | Per-DIMM mirror bits, bit (3 − rank) of each field |
| tccd_clk | input | 4 | tCCD_L in clocks (4..8) |
| vref_value | input | DIMMS*RANKS*VREF_W | VrefDQ value per slot |
| vref_range | input | DIMMS*RANKS | VrefDQ range per slot |
| vref_train_en | input | DIMMS*RANKS | VrefDQ training enable per slot |
| cmd_cke | output | 4 | Clock enables |
| cmd_cs_n | output | DIMMS*RANKS | Active-low chip selects |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_bank | output | 3 | {BG0, BA1, BA0} |
| cmd_addr | output | 16 | A13..A0 in bits 13:0, A17 in bit 14, BG1 in bit 15 |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with XPR_IDLE=24, MRS_IDLE=3 and MOD_IDLE=12, keeping the default two DIMMs of four ranks. The short wake-up hold-off lets a full eight-rank registered pass, with mirrored and B-side commands, finish in a few hundred cycles. The small MRS gap keeps every primary/B-side boundary inside the compared window. The tMOD gap keeps its production length of 12, so rank-to-rank spacing is checked exactly as it would run.

// File: rtl/mr6_pkg.sv
package mr6_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAKE_NOP,
        ST_MR6_A,
        ST_MR6_B,
        ST_TMOD_NOP,
        ST_GAP,
        ST_FINISH
    } seq_state_e;

    localparam int          ADDR_W     = 16;
    localparam int          BANK_W     = 3;
    localparam int          CKE_W      = 4;
    localparam int          TCCD_W     = 4;
    localparam int          TCCD_MIN   = 4;
    // {BG0, BA1, BA0} selecting mode register 6
    localparam logic [2:0]  MR6_BANK   = 3'b110;
    // B-side inversion: A3..A9, A11, A13 and the A17 carrier (bit 14)
    localparam logic [15:0] BSIDE_FLIP = 16'h6BF8;
    // bit 15 marks BG1 for the B-side DRAMs
    localparam logic [15:0] BSIDE_SET  = 16'h8000;
    localparam int          STACK_RANK_MIN = 2;

endpackage

// File: rtl/mr6_slot_find.sv
module mr6_slot_find
    import mr6_pkg::*;
#(
    parameter int DIMMS  = 2,
    parameter int RANKS  = 4,
    parameter int RCNT_W = 3,
    parameter int SLOT_W = 3
) (
    input  logic [DIMMS*RCNT_W-1:0] ranks_per_dimm,
    input  logic [SLOT_W:0]         from_slot,
    output logic                    found,
    output logic [SLOT_W-1:0]       slot
);
    localparam int SLOTS = DIMMS * RANKS;

    logic [SLOTS-1:0] populated;

    for (genvar d = 0; d < DIMMS; d++) begin : g_dimm
        for (genvar r = 0; r < RANKS; r++) begin : g_rank
            assign populated[d*RANKS+r] =
                ranks_per_dimm[d*RCNT_W +: RCNT_W] > RCNT_W'(r);
        end
    end

    // lowest populated slot at or above from_slot
    always_comb begin
        found = 1'b0;
        slot  = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (populated[i] && (i >= int'(from_slot))) begin
                found = 1'b1;
                slot  = SLOT_W'(i);
            end
        end
    end

endmodule

// File: rtl/mr6_word_enc.sv
module mr6_word_enc
    import mr6_pkg::*;
#(
    parameter int VREF_W = 6
) (
    input  logic [VREF_W-1:0] vref,
    input  logic              range_sel,
    input  logic              train_en,
    input  logic [TCCD_W-1:0] tccd_clk,
    input  logic              side_b,
    output logic [ADDR_W-1:0] addr,
    output logic [BANK_W-1:0] bank
);
    logic [ADDR_W-1:0] word_a;
    logic [2:0]        tccd_code;

    assign tccd_code = 3'(tccd_clk - TCCD_W'(TCCD_MIN));

    always_comb begin
        word_a               = '0;
        word_a[VREF_W-1:0]   = vref;
        word_a[6]            = range_sel;
        word_a[7]            = train_en;
        word_a[12:10]        = tccd_code;
    end

    always_comb begin
        if (side_b) begin
            addr = (word_a ^ BSIDE_FLIP) | BSIDE_SET;
            bank = ~MR6_BANK;
        end else begin
            addr = word_a;
            bank = MR6_BANK;
        end
    end

endmodule

// File: rtl/mr6_mirror.sv
module mr6_mirror
    import mr6_pkg::*;
(
    input  logic              mirror_en,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [BANK_W-1:0] bank_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic [BANK_W-1:0] bank_out
);
    localparam int NPAIR = 4;
    localparam int PAIR_LO [NPAIR] = '{3, 5, 7, 11};
    localparam int PAIR_HI [NPAIR] = '{4, 6, 8, 13};

    always_comb begin
        addr_out = addr_in;
        bank_out = bank_in;
        if (mirror_en) begin
            for (int p = 0; p < NPAIR; p++) begin
                addr_out[PAIR_LO[p]] = addr_in[PAIR_HI[p]];
                addr_out[PAIR_HI[p]] = addr_in[PAIR_LO[p]];
            end
            bank_out[0]  = bank_in[1];
            bank_out[1]  = bank_in[0];
            bank_out[2]  = addr_in[15];
            addr_out[15] = bank_in[2];
        end
    end

endmodule

// File: rtl/mr6_init_seq.sv
module mr6_init_seq
    import mr6_pkg::*;
#(
    parameter int DIMMS    = 2,
    parameter int RANKS    = 4,
    parameter int VREF_W   = 6,
    parameter int XPR_IDLE = 400,
    parameter int MRS_IDLE = 8,
    parameter int MOD_IDLE = 12
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            start,
    input  logic [DIMMS*3-1:0]              ranks_per_dimm,
    input  logic                            dimm_regd,
    input  logic                            stack_3ds,
    input  logic [DIMMS*RANKS-1:0]          mirror_mask,
    input  logic [3:0]                      tccd_clk,
    input  logic [DIMMS*RANKS*VREF_W-1:0]   vref_value,
    input  logic [DIMMS*RANKS-1:0]          vref_range,
    input  logic [DIMMS*RANKS-1:0]          vref_train_en,
    output logic [3:0]                      cmd_cke,
    output logic [DIMMS*RANKS-1:0]          cmd_cs_n,
    output logic                            cmd_ras_n,
    output logic                            cmd_cas_n,
    output logic                            cmd_we_n,
    output logic [2:0]                      cmd_bank,
    output logic [15:0]                     cmd_addr,
    output logic                            busy,
    output logic                            done
);
    localparam int SLOTS   = DIMMS * RANKS;
    localparam int RCNT_W  = 3;
    localparam int SLOT_W  = $clog2(SLOTS);
    localparam int RANK_W  = $clog2(RANKS);
    localparam int FROM_W  = SLOT_W + 1;
    localparam int MAX_A   = (XPR_IDLE > MRS_IDLE) ? XPR_IDLE : MRS_IDLE;
    localparam int MAX_ID  = (MAX_A > MOD_IDLE) ? MAX_A : MOD_IDLE;
    localparam int CNT_W   = $clog2(MAX_ID + 1);

    seq_state_e        state_q, state_d, ret_q, ret_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [SLOT_W-1:0] slot_q, slot_d;
    logic [FROM_W-1:0] from_q, from_d;
    logic              cke_on_q, cke_on_d;

    logic              scan_found;
    logic [SLOT_W-1:0] scan_slot;

    logic [VREF_W-1:0] vref_arr [SLOTS];
    logic [SLOTS-1:0]  stack_cs;
    logic [SLOTS-1:0]  rank_cs_n;
    logic [SLOT_W-1:0] mir_idx;
    logic [ADDR_W-1:0] enc_addr, mir_addr;
    logic [BANK_W-1:0] enc_bank, mir_bank;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        assign vref_arr[s] = vref_value[s*VREF_W +: VREF_W];
        assign stack_cs[s] = ((s % RANKS) >= STACK_RANK_MIN);
    end

    mr6_slot_find #(
        .DIMMS  (DIMMS),
        .RANKS  (RANKS),
        .RCNT_W (RCNT_W),
        .SLOT_W (SLOT_W)
    ) u_find (
        .ranks_per_dimm (ranks_per_dimm),
        .from_slot      (from_q),
        .found          (scan_found),
        .slot           (scan_slot)
    );

    mr6_word_enc #(
        .VREF_W (VREF_W)
    ) u_enc (
        .vref      (vref_arr[slot_q]),
        .range_sel (vref_range[slot_q]),
        .train_en  (vref_train_en[slot_q]),
        .tccd_clk  (tccd_clk),
        .side_b    (state_q == ST_MR6_B),
        .addr      (enc_addr),
        .bank      (enc_bank)
    );

    // mirror bit (RANKS-1-rank) of the DIMM's field
    assign mir_idx = {slot_q[SLOT_W-1:RANK_W], ~slot_q[RANK_W-1:0]};

    mr6_mirror u_mirror (
        .mirror_en (mirror_mask[mir_idx]),
        .addr_in   (enc_addr),
        .bank_in   (enc_bank),
        .addr_out  (mir_addr),
        .bank_out  (mir_bank)
    );

    assign rank_cs_n = ~((SLOTS'(1) << slot_q) | (stack_3ds ? stack_cs : '0));

    // next-state logic
    always_comb begin
        state_d  = state_q;
        ret_d    = ret_q;
        cnt_d    = cnt_q;
        slot_d   = slot_q;
        from_d   = from_q;
        cke_on_d = cke_on_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d  = ST_WAKE_NOP;
                    from_d   = '0;
                    cke_on_d = 1'b1;
                end
            end
            ST_WAKE_NOP: begin
                state_d = ST_GAP;
                cnt_d   = CNT_W'(XPR_IDLE - 1);
                ret_d   = ST_MR6_A;
            end
            ST_MR6_A: begin
                state_d = ST_GAP;
                cnt_d   = CNT_W'(MRS_IDLE - 1);
                ret_d   = dimm_regd ? ST_MR6_B : ST_TMOD_NOP;
            end
            ST_MR6_B: begin
                state_d = ST_GAP;
                cnt_d   = CNT_W'(MRS_IDLE - 1);
                ret_d   = ST_TMOD_NOP;
            end
            ST_TMOD_NOP: begin
                state_d = ST_GAP;
                cnt_d   = CNT_W'(MOD_IDLE - 1);
                ret_d   = ST_MR6_A;
                from_d  = FROM_W'(slot_q) + FROM_W'(1);
            end
            ST_GAP: begin
                if (cnt_q != '0) begin
                    cnt_d = cnt_q - CNT_W'(1);
                end else if (ret_q == ST_MR6_A) begin
                    if (scan_found) begin
                        state_d = ST_MR6_A;
                        slot_d  = scan_slot;
                    end else begin
                        state_d = ST_FINISH;
                    end
                end else begin
                    state_d = ret_q;
                end
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            ret_q    <= ST_IDLE;
            cnt_q    <= '0;
            slot_q   <= '0;
            from_q   <= '0;
            cke_on_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            ret_q    <= ret_d;
            cnt_q    <= cnt_d;
            slot_q   <= slot_d;
            from_q   <= from_d;
            cke_on_q <= cke_on_d;
        end
    end

    // outputs
    always_comb begin
        cmd_cke   = cke_on_q ? 4'hF : 4'h0;
        cmd_cs_n  = '1;
        cmd_ras_n = 1'b1;
        cmd_cas_n = 1'b1;
        cmd_we_n  = 1'b1;
        cmd_bank  = '0;
        cmd_addr  = '0;
        busy      = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_WAKE_NOP: begin
                busy    = 1'b1;
                cmd_cke = 4'hF;
            end
            ST_MR6_A, ST_MR6_B: begin
                busy       = 1'b1;
                cmd_cs_n   = rank_cs_n;
                cmd_ras_n  = 1'b0;
                cmd_cas_n  = 1'b0;
                cmd_we_n   = 1'b0;
                cmd_bank   = mir_bank;
                cmd_addr   = mir_addr;
                cmd_cke[1] = ~stack_3ds;
            end
            ST_TMOD_NOP: begin
                busy       = 1'b1;
                cmd_cs_n   = rank_cs_n;
                cmd_cke[1] = ~stack_3ds;
            end
            ST_GAP:    busy = 1'b1;
            ST_FINISH: done = 1'b1;
            default: ;
        endcase
    end

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    busy_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done));

    // R10
    idle_no_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cmd_cs_n == '1));

    // R5
    single_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stack_3ds |-> $onehot0(~cmd_cs_n));

    // R4
    mr6_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_ras_n |-> (!cmd_cas_n && !cmd_we_n && busy));

    // R11
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (state_q != ST_WAKE_NOP));

    // R12
    cke_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (cmd_cke == 4'hF));

endmodule

// File: tb/mr6_init_seq_tb_top.sv
`timescale 1ns/1ps
module mr6_init_seq_tb_top;
    localparam int XPR = 24;
    localparam int MRSI = 3;
    localparam int MODI = 12;

    typedef struct {
        logic [35:0] v;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [5:0]  ranks_per_dimm = '0;
    logic        dimm_regd = 1'b0;
    logic        stack_3ds = 1'b0;
    logic [7:0]  mirror_mask = '0;
    logic [3:0]  tccd_clk = 4'd4;
    logic [47:0] vref_value = 48'hA53C_9671_E24B;
    logic [7:0]  vref_range = 8'b1011_0010;
    logic [7:0]  vref_train_en = 8'b0110_1101;
    logic [3:0]  cmd_cke;
    logic [7:0]  cmd_cs_n;
    logic        cmd_ras_n, cmd_cas_n, cmd_we_n;
    logic [2:0]  cmd_bank;
    logic [15:0] cmd_addr;
    logic        busy, done;

    int   checks = 0;
    int   errors = 0;
    int   cyc = 0;
    exp_t q[$];

    always #2.5 clk = ~clk;

    mr6_init_seq #(
        .XPR_IDLE (XPR),
        .MRS_IDLE (MRSI),
        .MOD_IDLE (MODI)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .ranks_per_dimm(ranks_per_dimm), .dimm_regd(dimm_regd),
        .stack_3ds(stack_3ds), .mirror_mask(mirror_mask),
        .tccd_clk(tccd_clk), .vref_value(vref_value),
        .vref_range(vref_range), .vref_train_en(vref_train_en),
        .cmd_cke(cmd_cke), .cmd_cs_n(cmd_cs_n), .cmd_ras_n(cmd_ras_n),
        .cmd_cas_n(cmd_cas_n), .cmd_we_n(cmd_we_n), .cmd_bank(cmd_bank),
        .cmd_addr(cmd_addr), .busy(busy), .done(done)
    );

    function automatic logic [35:0] actual_vec();
        return {cmd_cke, cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n,
                cmd_bank, cmd_addr, busy, done};
    endfunction

    function automatic logic [35:0] mk(logic [3:0] cke, logic [7:0] cs,
                                       logic [2:0] rcw, logic [2:0] bk,
                                       logic [15:0] ad, logic bsy, logic dn);
        return {cke, cs, rcw, bk, ad, bsy, dn};
    endfunction

    task automatic check(logic [35:0] act, logic [35:0] exp, string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: one expected item per cycle, sampled mid-cycle
    always @(negedge clk) begin
        exp_t e;
        if (q.size() > 0) begin
            e = q.pop_front();
            check(actual_vec(), e.v, e.tag);
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 60000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [2:0] tccd_code(logic [3:0] t);
        case (t)
            4'd4: return 3'd0;
            4'd5: return 3'd1;
            4'd6: return 3'd2;
            4'd7: return 3'd3;
            default: return 3'd4;
        endcase
    endfunction

    task automatic push(logic [35:0] v, string tag);
        exp_t e;
        e.v = v;
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic push_gap(int n, string tag);
        for (int i = 0; i < n; i++)
            push(mk(4'hF, 8'hFF, 3'b111, 3'b000, 16'h0, 1'b1, 1'b0), tag);
    endtask

    task automatic push_run(string xt);
        for (int s = 0; s < 8; s++) begin
            int d = s / 4;
            int r = s % 4;
            int nr = int'(ranks_per_dimm[d*3 +: 3]);
            logic [15:0] w, a;
            logic [2:0]  b;
            logic [7:0]  cs;
            logic [3:0]  ck;
            logic        mir;
            string       st;
            if (r >= nr) continue;
            w = '0;
            w[5:0]   = vref_value[s*6 +: 6];
            w[6]     = vref_range[s];
            w[7]     = vref_train_en[s];
            w[12:10] = tccd_code(tccd_clk);
            cs = ~(8'b1 << s);
            if (stack_3ds) cs = cs & ~8'hCC;
            ck = stack_3ds ? 4'hD : 4'hF;
            mir = mirror_mask[d*4 + (3 - r)];
            st = {xt, stack_3ds ? " R6" : "", mir ? " R9" : ""};
            for (int side = 0; side < (dimm_regd ? 2 : 1); side++) begin
                a = w;
                b = 3'b110;
                if (side == 1) begin
                    a = (a ^ 16'h6BF8) | 16'h8000;
                    b = 3'b001;
                end
                if (mir) begin
                    logic [15:0] t;
                    logic [2:0]  tb;
                    t = a;
                    tb = b;
                    t[3] = a[4];  t[4] = a[3];
                    t[5] = a[6];  t[6] = a[5];
                    t[7] = a[8];  t[8] = a[7];
                    t[11] = a[13]; t[13] = a[11];
                    tb[0] = b[1]; tb[1] = b[0];
                    tb[2] = a[15]; t[15] = b[2];
                    a = t;
                    b = tb;
                end
                push(mk(ck, cs, 3'b000, b, a, 1'b1, 1'b0),
                     {side == 1 ? "R7" : "R3 R4 R5", st});
                push_gap(MRSI, {"R4", xt});
            end
            push(mk(ck, cs, 3'b111, 3'b000, 16'h0, 1'b1, 1'b0), {"R8", st});
            push_gap(MODI, {"R8", xt});
        end
    endtask

    task automatic run(bit mid_start, string xt);
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        push(mk(4'hF, 8'hFF, 3'b111, 3'b000, 16'h0, 1'b1, 1'b0), {"R2", xt});
        push_gap(XPR, {"R2", xt});
        push_run(xt);
        push(mk(4'hF, 8'hFF, 3'b111, 3'b000, 16'h0, 1'b0, 1'b1), {"R10", xt});
        push(mk(4'hF, 8'hFF, 3'b111, 3'b000, 16'h0, 1'b0, 1'b0), {"R12", xt});
        if (mid_start) begin
            repeat (30) @(posedge clk);
            #1 start = 1'b1;
            @(posedge clk); #1 start = 1'b0;
        end
        while (q.size() != 0) @(posedge clk);
        repeat (2) @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 during reset
        check(actual_vec(), mk(4'h0, 8'hFF, 3'b111, 3'b000, 16'h0, 1'b0, 1'b0), "R1 in reset");
        @(posedge clk); #1 rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1 after reset, before start
        check(actual_vec(), mk(4'h0, 8'hFF, 3'b111, 3'b000, 16'h0, 1'b0, 1'b0), "R1 idle");

        // unbuffered, two DIMMs, tCCD_L 4
        ranks_per_dimm = {3'd1, 3'd2}; dimm_regd = 0; stack_3ds = 0;
        mirror_mask = 8'h00; tccd_clk = 4'd4;
        run(1'b0, " udimm");

        // registered, fully populated, mirroring, tCCD_L 8
        ranks_per_dimm = {3'd4, 3'd4}; dimm_regd = 1;
        mirror_mask = {4'b0001, 4'b1010}; tccd_clk = 4'd8;
        run(1'b0, " rdimm");

        // DIMM 0 empty (R5 skip), 3DS, registered, tCCD_L 6
        ranks_per_dimm = {3'd2, 3'd0}; stack_3ds = 1;
        mirror_mask = {4'b1000, 4'b1111}; tccd_clk = 4'd6;
        run(1'b0, " 3ds R5");

        // no ranks: NOP, hold-off, done (R10)
        ranks_per_dimm = {3'd0, 3'd0}; stack_3ds = 0; dimm_regd = 0;
        run(1'b0, " empty R10");

        // start while busy is ignored, tCCD_L 5
        ranks_per_dimm = {3'd1, 3'd1}; tccd_clk = 4'd5; mirror_mask = 8'h00;
        run(1'b1, " R11");

        // tCCD_L 7, three ranks on DIMM 0
        ranks_per_dimm = {3'd0, 3'd3}; tccd_clk = 4'd7; mirror_mask = 8'h40;
        run(1'b0, " R3 tccd7");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule